// File: doc/BRIEF.md
# Byte FIFO Pair with Programmable Trigger Interrupts

This block buffers audio bytes between a serial shift register and a processor register port. Bytes from the receive shift register enter an 8-entry receive FIFO, which the processor drains through a data register. Bytes the processor writes to that data register enter an 8-entry transmit FIFO, which the transmit shift register drains one byte at a time. A control register picks a trigger level for each FIFO.

A receive-full flag rises when the receive FIFO holds at least its trigger level. A transmit-empty flag rises when the transmit FIFO holds fewer bytes than its trigger level. Four sticky error flags record refused pushes and pops. The two level flags, each ANDed with its own enable bit, drive the `rx_irq` and `tx_irq` request outputs.

Each of the six status flags is a small state machine. Its states are `FLG_CLEAR` (reads 0), `FLG_RAISED` (reads 1, not yet seen by software) and `FLG_ARMED` (reads 1, seen by a status read). There are three transitions:
- CLEAR to RAISED when the flag's set condition is true.
- RAISED to ARMED on a status-register read.
- ARMED to CLEAR on a status-register write that puts 0 in the flag's bit.

Register map, selected by `reg_addr`:
- 0: control register.
- 1: status register.
- 2: data register.
- 3: reads 0.

Read data is combinational while `reg_rd` is high and is 0 otherwise. A write or a pop takes effect at the clock edge.

Top module: `sff_trig_fifo`

## Requirements
- R1: After reset, the control register reads 0x00, the status register reads 0x00 until the first clock edge after reset release, and both `rx_irq` and `tx_irq` are 0.
- R2: The receive trigger code sits in control bits [5:4] and maps 00/01/10/11 to 1/2/4/6 bytes. The receive-full flag (status bit 0) is 1 on the cycle after the receive byte count first becomes greater than or equal to the selected level.
- R3: The transmit trigger code sits in control bits [7:6] and maps 00/01/10/11 to 7/6/4/2 bytes. The transmit-empty flag (status bit 1) is 1 on the cycle after the transmit byte count first drops below the selected level.
- R4: `rx_irq` equals the receive-full flag AND the receive enable (control bit 1). `tx_irq` equals the transmit-empty flag AND the transmit enable (control bit 2). Clearing the enable removes the request while the flag stays 1.
- R5: Control bits 3 and 0 always read 0, and writes to them are ignored.
- R6: A status flag clears only when a status write puts 0 in its bit after a status read has returned it as 1. A 0 written without that read, or a 1 written, has no effect. If the set condition still holds, the flag returns to 1 one cycle after the clear.
- R7: Both FIFOs are first-in first-out, 8 bytes deep. A read of address 2 pops the receive head. A write to address 2 pushes the transmit FIFO. `tx_byte` shows the transmit head, and `tx_pop` consumes it.
- R8: A push into a full FIFO is dropped. It sets the sticky status bit 2 for the receive FIFO or bit 3 for the transmit FIFO.
- R9: A pop from an empty FIFO leaves it empty and returns 0, on `reg_rdata` or on `tx_byte`. It sets the sticky status bit 4 for the receive FIFO or bit 5 for the transmit FIFO.
- R10: A control write takes effect at its clock edge. Flag evaluation uses the new trigger level from that edge, so a flag it satisfies reads 1 one cycle later.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_rd | input | 1 | Register read strobe |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register select: 0 control, 1 status, 2 data |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Register read data, 0 when not reading |
| rx_push | input | 1 | Receive shift register delivers a byte |
| rx_byte | input | 8 | Received byte |
| tx_pop | input | 1 | Transmit shift register takes the head byte |
| tx_byte | output | 8 | Transmit FIFO head, 0 when empty |
| rx_irq | output | 1 | Receive request |
| tx_irq | output | 1 | Transmit request |

## Verification
Two functions can fall in the same cycle: a status write that clears a flag, and a set condition that still holds. The bench provokes this by arming the transmit-empty flag while the transmit FIFO is empty, then writing 0 to its bit. It judges the result by seeing `tx_irq` low for exactly one cycle and then high again. A second case uses a control write that lowers the receive trigger level below the byte count already stored. The bench expects the request to stay low through the edge of that write and to rise one cycle later.

// File: rtl/sff_pkg.sv
`timescale 1ns/1ps
package sff_pkg;

    localparam int BYTE_W = 8;

    // register select codes
    localparam logic [1:0] ADDR_CTRL = 2'd0;
    localparam logic [1:0] ADDR_STAT = 2'd1;
    localparam logic [1:0] ADDR_DATA = 2'd2;

    // status bit positions
    localparam int ST_RDF   = 0;
    localparam int ST_TDE   = 1;
    localparam int ST_RXOVF = 2;
    localparam int ST_TXOVF = 3;
    localparam int ST_RXUDF = 4;
    localparam int ST_TXUDF = 5;
    localparam int NFLAG    = 6;

    typedef enum logic [1:0] {
        FLG_CLEAR  = 2'd0,
        FLG_RAISED = 2'd1,
        FLG_ARMED  = 2'd2
    } flag_state_e;

    // nonlinear receive level map; transmit level is depth minus this
    function automatic int level_of(input logic [1:0] code);
        int lv;
        unique case (code)
            2'd0:    lv = 1;
            2'd1:    lv = 2;
            2'd2:    lv = 4;
            default: lv = 6;
        endcase
        return lv;
    endfunction

endpackage

// File: rtl/sff_fifo.sv
`timescale 1ns/1ps
module sff_fifo #(
    parameter int DEPTH = 8,
    parameter int DW    = 8,
    parameter int CW    = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          push_i,
    input  logic [DW-1:0] din_i,
    input  logic          pop_i,
    output logic [DW-1:0] dout_o,
    output logic [CW-1:0] count_o,
    output logic          ovf_o,
    output logic          udf_o
);
    localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam logic [PW-1:0] LAST  = PW'(DEPTH - 1);
    localparam logic [CW-1:0] FULLC = CW'(DEPTH);

    logic [DW-1:0] mem [DEPTH];
    logic [PW-1:0] wptr, rptr;
    logic [CW-1:0] cnt;
    logic          full, empty, do_push, do_pop;

    always_comb begin
        full    = (cnt == FULLC);
        empty   = (cnt == '0);
        do_push = push_i && !full;
        do_pop  = pop_i && !empty;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wptr <= '0;
            rptr <= '0;
            cnt  <= '0;
        end else begin
            if (do_push) wptr <= (wptr == LAST) ? '0 : wptr + 1'b1;
            if (do_pop)  rptr <= (rptr == LAST) ? '0 : rptr + 1'b1;
            unique case ({do_push, do_pop})
                2'b10:   cnt <= cnt + 1'b1;
                2'b01:   cnt <= cnt - 1'b1;
                default: cnt <= cnt;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (do_push) mem[wptr] <= din_i;
    end

    always_comb begin
        dout_o  = empty ? '0 : mem[rptr];
        count_o = cnt;
        ovf_o   = push_i && full;
        udf_o   = pop_i && empty;
    end

    // R7
    count_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        count_o <= FULLC);

    // R8
    full_push_chk: assert property (@(posedge clk) disable iff (!rst_n)
        push_i && (count_o == FULLC) && !pop_i |=> count_o == FULLC);

    // R9
    empty_pop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        pop_i && (count_o == '0) && !push_i |=> count_o == '0);

endmodule

// File: rtl/sff_flag.sv
`timescale 1ns/1ps
module sff_flag (
    input  logic clk,
    input  logic rst_n,
    input  logic set_i,
    input  logic rd_i,
    input  logic clr_i,
    output logic flag_o
);
    import sff_pkg::*;

    flag_state_e st, st_nx;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st <= FLG_CLEAR;
        else        st <= st_nx;
    end

    always_comb begin
        st_nx = st;
        unique case (st)
            FLG_CLEAR:  if (set_i) st_nx = FLG_RAISED;
            FLG_RAISED: if (rd_i)  st_nx = FLG_ARMED;
            FLG_ARMED:  if (clr_i) st_nx = FLG_CLEAR;
            default:               st_nx = FLG_CLEAR;
        endcase
    end

    always_comb begin
        flag_o = (st != FLG_CLEAR);
    end

    // R6
    flag_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(flag_o) |-> $past(clr_i));

    // R6
    flag_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(flag_o) |-> $past(set_i));

endmodule

// File: rtl/sff_trig_fifo.sv
`timescale 1ns/1ps
module sff_trig_fifo #(
    parameter int DEPTH = 8
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       reg_rd,
    input  logic       reg_wr,
    input  logic [1:0] reg_addr,
    input  logic [7:0] reg_wdata,
    output logic [7:0] reg_rdata,
    input  logic       rx_push,
    input  logic [7:0] rx_byte,
    input  logic       tx_pop,
    output logic [7:0] tx_byte,
    output logic       rx_irq,
    output logic       tx_irq
);
    import sff_pkg::*;

    localparam int CW = $clog2(DEPTH + 1);

    logic [1:0] tx_code, rx_code;
    logic       tx_en, rx_en;

    logic       ctrl_wr, stat_rd, stat_wr, data_rd, data_wr;
    logic [BYTE_W-1:0] rx_head;
    logic [CW-1:0]     rx_cnt, tx_cnt, rx_lvl, tx_lvl;
    logic              rx_ovf, rx_udf, tx_ovf, tx_udf;
    logic [NFLAG-1:0]  flag_set, flag_clr, flags;

    always_comb begin
        ctrl_wr = reg_wr && (reg_addr == ADDR_CTRL);
        stat_rd = reg_rd && (reg_addr == ADDR_STAT);
        stat_wr = reg_wr && (reg_addr == ADDR_STAT);
        data_rd = reg_rd && (reg_addr == ADDR_DATA);
        data_wr = reg_wr && (reg_addr == ADDR_DATA);
    end

    // control register: [7:6] tx code, [5:4] rx code, [2] tx enable, [1] rx enable
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            tx_code <= 2'd0;
            rx_code <= 2'd0;
            tx_en   <= 1'b0;
            rx_en   <= 1'b0;
        end else if (ctrl_wr) begin
            tx_code <= reg_wdata[7:6];
            rx_code <= reg_wdata[5:4];
            tx_en   <= reg_wdata[2];
            rx_en   <= reg_wdata[1];
        end
    end

    sff_fifo #(.DEPTH(DEPTH), .DW(BYTE_W), .CW(CW)) u_rx_fifo (
        .clk     (clk),
        .rst_n   (rst_n),
        .push_i  (rx_push),
        .din_i   (rx_byte),
        .pop_i   (data_rd),
        .dout_o  (rx_head),
        .count_o (rx_cnt),
        .ovf_o   (rx_ovf),
        .udf_o   (rx_udf)
    );

    sff_fifo #(.DEPTH(DEPTH), .DW(BYTE_W), .CW(CW)) u_tx_fifo (
        .clk     (clk),
        .rst_n   (rst_n),
        .push_i  (data_wr),
        .din_i   (reg_wdata),
        .pop_i   (tx_pop),
        .dout_o  (tx_byte),
        .count_o (tx_cnt),
        .ovf_o   (tx_ovf),
        .udf_o   (tx_udf)
    );

    always_comb begin
        rx_lvl = CW'(level_of(rx_code));
        tx_lvl = CW'(DEPTH - level_of(tx_code));
        flag_set           = '0;
        flag_set[ST_RDF]   = (rx_cnt >= rx_lvl);
        flag_set[ST_TDE]   = (tx_cnt <  tx_lvl);
        flag_set[ST_RXOVF] = rx_ovf;
        flag_set[ST_TXOVF] = tx_ovf;
        flag_set[ST_RXUDF] = rx_udf;
        flag_set[ST_TXUDF] = tx_udf;
        flag_clr = stat_wr ? ~reg_wdata[NFLAG-1:0] : '0;
    end

    for (genvar g = 0; g < NFLAG; g++) begin : g_flag
        sff_flag u_flag (
            .clk    (clk),
            .rst_n  (rst_n),
            .set_i  (flag_set[g]),
            .rd_i   (stat_rd),
            .clr_i  (flag_clr[g]),
            .flag_o (flags[g])
        );
    end

    always_comb begin
        reg_rdata = '0;
        if (reg_rd) begin
            unique case (reg_addr)
                ADDR_CTRL: reg_rdata = {tx_code, rx_code, 1'b0, tx_en, rx_en, 1'b0};
                ADDR_STAT: reg_rdata = {{(8-NFLAG){1'b0}}, flags};
                ADDR_DATA: reg_rdata = rx_head;
                default:   reg_rdata = '0;
            endcase
        end
        rx_irq = flags[ST_RDF] && rx_en;
        tx_irq = flags[ST_TDE] && tx_en;
    end

    // R2
    rdf_level_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_cnt >= rx_lvl) && !flag_clr[ST_RDF] |=> flags[ST_RDF]);

    // R3
    tde_level_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_cnt < tx_lvl) && !flag_clr[ST_TDE] |=> flags[ST_TDE]);

    // R4
    tx_irq_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(tx_irq) |-> $past(flag_clr[ST_TDE]) || $past(ctrl_wr && !reg_wdata[2]));

    // R10
    ctrl_take_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ctrl_wr |=> (tx_code == $past(reg_wdata[7:6])) && (rx_code == $past(reg_wdata[5:4])));

endmodule

// File: tb/sff_trig_fifo_bench.sv
`timescale 1ns/1ps
module sff_trig_fifo_bench;

    logic       clk = 1'b0;
    logic       rst_n;
    logic       reg_rd, reg_wr, rx_push, tx_pop;
    logic [1:0] reg_addr;
    logic [7:0] reg_wdata, rx_byte;
    logic [7:0] reg_rdata, tx_byte;
    logic       rx_irq, tx_irq;

    int n_tests = 0;
    int n_fail  = 0;
    bit done    = 1'b0;

    always #2.5 clk = ~clk;

    sff_trig_fifo u_sff_trig_fifo (
        .clk       (clk),
        .rst_n     (rst_n),
        .reg_rd    (reg_rd),
        .reg_wr    (reg_wr),
        .reg_addr  (reg_addr),
        .reg_wdata (reg_wdata),
        .reg_rdata (reg_rdata),
        .rx_push   (rx_push),
        .rx_byte   (rx_byte),
        .tx_pop    (tx_pop),
        .tx_byte   (tx_byte),
        .rx_irq    (rx_irq),
        .tx_irq    (tx_irq)
    );

    task automatic check(input string tag, input int got, input int exp);
        n_tests++;
        if (got != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", tag, got, exp);
        end
    endtask

    function automatic int rx_level(input int code);
        return (code == 3) ? 6 : (1 << code);
    endfunction

    task automatic bus_wr(input logic [1:0] a, input logic [7:0] d);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        @(posedge clk); #1;
        reg_wr = 1'b0;
    endtask

    task automatic bus_rd(input logic [1:0] a, output logic [7:0] d);
        reg_rd = 1'b1; reg_addr = a;
        #1 d = reg_rdata;
        @(posedge clk); #1;
        reg_rd = 1'b0;
    endtask

    task automatic idle(input int n);
        repeat (n) @(posedge clk);
        #1;
    endtask

    task automatic rx_in(input logic [7:0] b);
        rx_push = 1'b1; rx_byte = b;
        @(posedge clk); #1;
        rx_push = 1'b0;
    endtask

    task automatic tx_take(output logic [7:0] b);
        b = tx_byte;
        tx_pop = 1'b1;
        @(posedge clk); #1;
        tx_pop = 1'b0;
    endtask

    task automatic clear_all();
        logic [7:0] d;
        bus_rd(2'd1, d);
        bus_wr(2'd1, 8'h00);
    endtask

    task automatic report();
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    endtask

    initial begin
        #1000000;
        if (!done) begin
            n_tests++;
            n_fail++;
            $display("FAIL watchdog (all requirements): actual timeout expected completion");
            report();
            $finish;
        end
    end

    initial begin
        logic [7:0] d;
        logic [7:0] b;
        rst_n = 1'b0; reg_rd = 0; reg_wr = 0; rx_push = 0; tx_pop = 0;
        reg_addr = 0; reg_wdata = 0; rx_byte = 0;
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;

        // R1 reset state
        bus_rd(2'd1, d); check("R1 status", d, 0);
        bus_rd(2'd0, d); check("R1 control", d, 0);
        check("R1 rx_irq", rx_irq, 0);
        check("R1 tx_irq", tx_irq, 0);

        // R5 reserved bits
        bus_wr(2'd0, 8'hFF);
        bus_rd(2'd0, d); check("R5 reserved readback", d, 8'hF6);
        bus_wr(2'd0, 8'h00);

        // R2 / R4 / R7 receive sweep over all codes and fill levels
        for (int code = 0; code < 4; code++) begin
            bus_wr(2'd0, 8'((code << 4) | 2));
            clear_all();
            idle(1);
            check("R2 rdf idle", rx_irq, 0);
            for (int n = 1; n <= 8; n++) begin
                rx_in(8'(code * 16 + n));
                idle(1);
                bus_rd(2'd1, d);
                check("R2 rdf level", d[0], int'(n >= rx_level(code)));
                check("R4 rx_irq", rx_irq, int'(n >= rx_level(code)));
            end
            for (int k = 1; k <= 8; k++) begin
                bus_rd(2'd2, d);
                check("R7 rx order", d, code * 16 + k);
            end
            bus_wr(2'd1, 8'h00);
            idle(1);
            check("R6 rdf cleared", rx_irq, 0);
        end

        // R3 / R4 / R7 transmit sweep
        for (int code = 0; code < 4; code++) begin
            bus_wr(2'd0, 8'((code << 6) | 4));
            for (int k = 1; k <= 8; k++) bus_wr(2'd2, 8'(8'h40 + code * 16 + k));
            idle(1);
            clear_all();
            idle(1);
            bus_rd(2'd1, d);
            check("R3 tde full", d[1], 0);
            check("R4 tx_irq full", tx_irq, 0);
            for (int k = 1; k <= 8; k++) begin
                tx_take(b);
                check("R7 tx order", b, 8'h40 + code * 16 + k);
                idle(1);
                check("R3 tde level", tx_irq, int'((8 - k) < (8 - rx_level(code))));
            end
        end

        // R6 clear protocol (tx empty, code 3, enable on)
        bus_wr(2'd1, 8'h00);
        idle(1);
        check("R6 unread clear ignored", tx_irq, 1);
        bus_rd(2'd1, d);
        check("R6 tde read", d[1], 1);
        bus_wr(2'd1, 8'hFF);
        idle(1);
        check("R6 write one ignored", tx_irq, 1);
        bus_wr(2'd1, 8'h00);
        check("R6 cleared", tx_irq, 0);
        idle(1);
        check("R6 re-raised", tx_irq, 1);

        // R4 enable removal
        bus_wr(2'd0, 8'h00);
        check("R4 enable off", tx_irq, 0);
        bus_rd(2'd1, d);
        check("R4 flag kept", d[1], 1);

        // R10 trigger change
        bus_wr(2'd0, 8'h32);
        for (int k = 1; k <= 3; k++) rx_in(8'(8'h50 + k));
        idle(1);
        check("R10 below level", rx_irq, 0);
        bus_wr(2'd0, 8'h12);
        check("R10 same edge", rx_irq, 0);
        idle(1);
        check("R10 next cycle", rx_irq, 1);
        for (int k = 1; k <= 3; k++) begin
            bus_rd(2'd2, d);
            check("R7 rx order short", d, 8'h50 + k);
        end
        clear_all();

        // R8 / R9 receive overflow and underflow
        for (int k = 1; k <= 9; k++) rx_in(8'(8'h80 + k));
        idle(1);
        bus_rd(2'd1, d);
        check("R8 rx overflow bit", d[2], 1);
        check("R8 tx overflow bit quiet", d[3], 0);
        for (int k = 1; k <= 8; k++) begin
            bus_rd(2'd2, d);
            check("R8 rx kept order", d, 8'h80 + k);
        end
        bus_rd(2'd2, d);
        check("R9 rx empty data", d, 0);
        idle(1);
        bus_rd(2'd1, d);
        check("R9 rx underflow bit", d[4], 1);

        // R8 / R9 transmit overflow and underflow
        for (int k = 1; k <= 9; k++) bus_wr(2'd2, 8'(8'hC0 + k));
        idle(1);
        bus_rd(2'd1, d);
        check("R8 tx overflow bit", d[3], 1);
        for (int k = 1; k <= 8; k++) begin
            tx_take(b);
            check("R8 tx kept order", b, 8'hC0 + k);
        end
        tx_take(b);
        check("R9 tx empty byte", b, 0);
        idle(1);
        bus_rd(2'd1, d);
        check("R9 tx underflow bit", d[5], 1);

        // R6 sticky bits clear after read-then-write-zero
        clear_all();
        idle(1);
        bus_rd(2'd1, d);
        check("R6 sticky cleared", int'(d & 8'h3C), 0);

        done = 1'b1;
        report();
        $finish;
    end

endmodule